// File: doc/BRIEF.md
# Multi-Tap Delay Line over a Shared Ring Buffer

The block holds one circular buffer of input samples and presents several delayed copies of the input stream at once. Tap k shows the sample that arrived a fixed number of sample strobes earlier; that lag is set per tap when the block is elaborated. A new sample is offered on `smp_in` together with a one-cycle `smp_en` strobe. The sample is written into the ring, and the write pointer then moves on by one entry.

The buffer has only one read port, so it is not read for all taps in parallel. After each write, a small sequencer walks through the taps in ascending order, one tap per clock. Each word it reads is parked in that tap's own output register. When the last tap register has been loaded, `tap_vld` pulses for one cycle. This relies on strobes being sparse: at least N+1 clocks between strobes, where N is the number of taps. A strobe that comes too early is still stored. It raises `overrun`, and the readout starts over for the newer sample.

Top module: `multitap_delay`

## Requirements
- R1: After reset, every tap output reads zero and both `tap_vld` and `overrun` are low. The ring contents are also zero, so a tap whose lag reaches back before the first written sample shows zero.
- R2: When `tap_vld` is high, tap k holds the sample written TAP_LAG[k] strobes before the newest one, or zero if that many samples have not yet been written.
- R3: `smp_in` is ignored on cycles without `smp_en`. Such cycles leave the tap outputs and the stored history unchanged.
- R4: `tap_vld` is a single-cycle pulse. It is high in the cycle that follows the N-th rising edge after the edge that samples the strobe.
- R5: Taps are reloaded one per clock in ascending index order. Tap 0 takes its new value at the first edge after the strobe edge, and tap k at edge k+1.
- R6: A strobe that is sampled while a readout is still running is written to the ring anyway. `overrun` is high for the one cycle after that edge. The interrupted readout never produces `tap_vld`, and a full readout of the new sample follows with `tap_vld` N clocks later.
- R7: Strobes spaced exactly N+1 clocks apart never raise `overrun`, and every one of them produces its own `tap_vld` pulse.
- R8: Samples are W bits wide (default 1), and the whole word is carried. Tap k appears on `tap_out[k*W +: W]`.
- R9: The ring depth is the smallest power of two above the largest lag. All addresses wrap modulo that depth, so results stay correct after the pointer has wrapped many times.
- R10: Outside a readout, `tap_out` holds its last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Sample strobe, one cycle per sample |
| smp_in | input | W | Sample value, taken when `smp_en` is high |
| tap_out | output | NTAP*W | Tap registers, tap k in bits [k*W +: W] |
| tap_vld | output | 1 | One-cycle pulse when all taps reflect the newest sample |
| overrun | output | 1 | One-cycle pulse after a strobe that arrived during a readout |

## Verification
The hardest situation to reach from the ports is a strobe that lands on the very last readout cycle. At that edge the final tap is captured for the old sample, its valid pulse must be withheld, and the sequencer must restart. The stimulus reaches it by timing a second strobe exactly N clocks after the first. A second case places a strobe only two clocks after the first. In both cases the bench's history model counts the early sample as written. Long runs of back-to-back strobes at the minimum legal spacing carry the pointer around the ring several times, and idle stretches with a toggling `smp_in` show that unstrobed data never leaks in.

// File: rtl/mtd_pkg.sv
package mtd_pkg;

    // Smallest power of two strictly greater than the largest lag.
    function automatic int unsigned ring_depth(input int unsigned max_lag);
        return 1 << $clog2(max_lag + 1);
    endfunction

    // Index width for a count of items, never below one bit.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mtd_store.sv
module mtd_store #(
    parameter int unsigned W     = 1,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

    // R2
    wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we) |-> mem_q[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/mtd_sequencer.sv
module mtd_sequencer #(
    parameter int unsigned NTAP          = 4,
    parameter int unsigned TAP_LAG [NTAP] = '{1, 3, 6, 10},
    parameter int unsigned AW            = 4,
    parameter int unsigned IW            = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_en,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          cap_en,
    output logic [IW-1:0] cap_idx,
    output logic          tap_vld,
    output logic          overrun
);

    localparam logic [IW-1:0] LAST = IW'(NTAP - 1);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic          busy;
        logic [IW-1:0] idx;
        logic          vld;
        logic          ovr;
    } seq_t;

    seq_t st_d, st_q;
    logic [AW-1:0] lag_sel;

    // Lag for the tap being read this cycle
    always_comb begin
        lag_sel = '0;
        for (int k = 0; k < NTAP; k++) begin
            if (IW'(k) == st_q.idx) lag_sel = AW'(TAP_LAG[k]);
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.ovr = 1'b0;
        if (st_q.busy) begin
            if (st_q.idx == LAST) begin
                st_d.busy = 1'b0;
                st_d.vld  = !smp_en;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
        if (smp_en) begin
            st_d.wptr = st_q.wptr + 1'b1;
            st_d.busy = 1'b1;
            st_d.idx  = '0;
            st_d.ovr  = st_q.busy;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Newest sample sits one entry behind the write pointer
    assign we      = smp_en;
    assign waddr   = st_q.wptr;
    assign raddr   = st_q.wptr - AW'(1) - lag_sel;
    assign cap_en  = st_q.busy;
    assign cap_idx = st_q.idx;
    assign tap_vld = st_q.vld;
    assign overrun = st_q.ovr;

    // R6
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(smp_en));

    // R4
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tap_vld |=> !tap_vld);

    // R3
    wptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(smp_en) |-> $stable(st_q.wptr));

    // R5
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> st_q.idx <= LAST);

endmodule

// File: rtl/mtd_tap_bank.sv
module mtd_tap_bank #(
    parameter int unsigned W    = 1,
    parameter int unsigned NTAP = 4,
    parameter int unsigned IW   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [IW-1:0]     cap_idx,
    input  logic [W-1:0]      rd_data,
    output logic [NTAP*W-1:0] taps
);

    logic [W-1:0] taps_d [NTAP];
    logic [W-1:0] taps_q [NTAP];

    for (genvar k = 0; k < NTAP; k++) begin : g_tap
        always_comb begin
            taps_d[k] = taps_q[k];
            if (cap_en && cap_idx == IW'(k)) taps_d[k] = rd_data;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) taps_q[k] <= '0;
            else        taps_q[k] <= taps_d[k];
        end

        assign taps[k*W +: W] = taps_q[k];
    end

endmodule

// File: rtl/multitap_delay.sv
module multitap_delay #(
    parameter int unsigned W             = 1,
    parameter int unsigned NTAP          = 4,
    parameter int unsigned TAP_LAG [NTAP] = '{1, 3, 6, 10}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_en,
    input  logic [W-1:0]      smp_in,
    output logic [NTAP*W-1:0] tap_out,
    output logic              tap_vld,
    output logic              overrun
);

    localparam int unsigned DEPTH = mtd_pkg::ring_depth(TAP_LAG[NTAP-1]);
    localparam int unsigned AW    = mtd_pkg::idx_bits(DEPTH);
    localparam int unsigned IW    = mtd_pkg::idx_bits(NTAP);

    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [W-1:0]  rdata;
    logic          cap_en;
    logic [IW-1:0] cap_idx;

    mtd_sequencer #(
        .NTAP(NTAP), .TAP_LAG(TAP_LAG), .AW(AW), .IW(IW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en),
        .we(we), .waddr(waddr), .raddr(raddr),
        .cap_en(cap_en), .cap_idx(cap_idx),
        .tap_vld(tap_vld), .overrun(overrun)
    );

    mtd_store #(
        .W(W), .DEPTH(DEPTH), .AW(AW)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr),
        .wdata(smp_in), .raddr(raddr), .rdata(rdata)
    );

    mtd_tap_bank #(
        .W(W), .NTAP(NTAP), .IW(IW)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_idx(cap_idx),
        .rd_data(rdata), .taps(tap_out)
    );

    // Lags must be positive and strictly increasing
    initial begin
        for (int k = 0; k < NTAP; k++) begin
            lag_min_chk: assert (TAP_LAG[k] >= 1);
            if (k > 0) begin
                lag_order_chk: assert (TAP_LAG[k] > TAP_LAG[k-1]);
            end
        end
    end

    // R10
    tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cap_en) |-> $stable(tap_out));

    // R2
    vld_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tap_vld |-> $past(cap_en));

endmodule

// File: tb/sim_multitap_delay.sv
module sim_multitap_delay;

    localparam int CLK_PERIOD = 10;
    localparam int unsigned W = 4;
    localparam int unsigned N = 4;
    localparam int unsigned LAG [N] = '{1, 3, 6, 10};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           smp_en = 1'b0;
    logic [W-1:0]   smp_in = '0;
    logic [N*W-1:0] tap_out;
    logic           tap_vld;
    logic           overrun;

    int total = 0;
    int bad   = 0;
    int hist[$];

    multitap_delay #(.W(W), .NTAP(N), .TAP_LAG(LAG)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_in(smp_in),
        .tap_out(tap_out), .tap_vld(tap_vld), .overrun(overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_tap(input int k);
        int pos = hist.size() - 1 - int'(LAG[k]);
        return (pos >= 0) ? hist[pos] : 0;
    endfunction

    function automatic int tap(input int k);
        return int'(tap_out[k*W +: W]);
    endfunction

    task automatic check_all_taps(input string req);
        for (int k = 0; k < N; k++) chk(req, tap(k), exp_tap(k));
    endtask

    // Called at a falling edge; strobe is sampled at the next rising edge.
    task automatic strobe_and_read(input int val);
        int old_last = tap(N-1);
        smp_en = 1'b1;
        smp_in = W'(val);
        hist.push_back(val);
        @(negedge clk);
        smp_en = 1'b0;
        smp_in = ~W'(val);
        chk("R4 vld low after strobe", int'(tap_vld), 0);
        chk("R7 no overrun at legal spacing", int'(overrun), 0);
        for (int c = 1; c <= int'(N); c++) begin
            @(negedge clk);
            if (c == 1) begin
                chk("R5 tap0 first", tap(0), exp_tap(0));
                if (old_last != exp_tap(N-1))
                    chk("R5 last tap not yet", tap(N-1), old_last);
            end
            if (c < int'(N)) chk("R4 vld early", int'(tap_vld), 0);
            else begin
                chk("R4 vld on time", int'(tap_vld), 1);
                check_all_taps("R2 tap values");
            end
        end
    endtask

    task automatic t_reset();
        chk("R1 taps zero", int'(tap_out), 0);
        chk("R1 vld low", int'(tap_vld), 0);
        chk("R1 overrun low", int'(overrun), 0);
    endtask

    task automatic t_stream(input int count, input int seed);
        for (int i = 0; i < count; i++) strobe_and_read((i * 7 + seed) & 15);
    endtask

    task automatic t_idle(input int cycles);
        logic [N*W-1:0] held = tap_out;
        for (int c = 0; c < cycles; c++) begin
            smp_in = W'(c * 5 + 1);
            @(negedge clk);
            chk("R3 R10 taps held", int'(tap_out), int'(held));
            chk("R3 no vld", int'(tap_vld), 0);
        end
    endtask

    task automatic t_overrun(input int gap, input int va, input int vb);
        smp_en = 1'b1;
        smp_in = W'(va);
        hist.push_back(va);
        @(negedge clk);
        smp_en = 1'b0;
        for (int c = 1; c < gap; c++) begin
            @(negedge clk);
            chk("R6 no early vld", int'(tap_vld), 0);
        end
        smp_en = 1'b1;
        smp_in = W'(vb);
        hist.push_back(vb);
        @(negedge clk);
        smp_en = 1'b0;
        chk("R6 overrun raised", int'(overrun), 1);
        chk("R6 aborted vld", int'(tap_vld), 0);
        for (int c = 1; c <= int'(N); c++) begin
            @(negedge clk);
            if (c == 1) chk("R6 overrun one cycle", int'(overrun), 0);
            if (c < int'(N)) chk("R6 vld early", int'(tap_vld), 0);
            else begin
                chk("R6 vld after restart", int'(tap_vld), 1);
                check_all_taps("R6 taps after restart");
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        // R1 R2: leading samples, taps reach back past history
        t_stream(12, 3);
        // R3 R10: idle with wiggling input
        t_idle(9);
        // R8: full-width values
        strobe_and_read(15);
        strobe_and_read(8);
        // R6: early strobe two clocks in, then at the last readout cycle
        t_overrun(2, 5, 10);
        t_idle(2);
        t_overrun(int'(N), 12, 6);
        // R7 R9: many minimum-spaced samples, pointer wraps several times
        t_stream(40, 11);
        t_idle(3);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule